// File: doc/BRIEF.md
# DRAM Burst Strobe Sequencer

This block produces the row strobe, column strobe and write-enable timing for one four-beat burst to an EDO or fast-page-mode DRAM bank. An 8-bit configuration register holds three fields: the read burst rate, the write burst rate and the leadoff selection. A request names its direction, its access class and the DRAM type of the target bank. At the clock edge that accepts a request, the sequencer captures the spacing, precharge, row-to-column and column-wait counts. It then steps through its states, one countdown counter paced by those counts.

The states are IDLE, PRECH, ROW, COL, CAS, GAP and DONE. IDLE to COL is taken for a page hit. IDLE to PRECH is taken for a page miss. IDLE to ROW is taken for a row miss. PRECH leads to ROW when the precharge count expires. ROW leads to COL when the row-to-column count expires. COL leads to CAS when the column wait expires. CAS leads to GAP for beats one to three. CAS leads to DONE after the fourth beat. GAP returns to CAS when the beat spacing is used up. DONE always returns to IDLE. Once the first burst has completed, the row strobe stays asserted while the sequencer is idle, which models an open page.

Top module: `dram_burst_seq`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are 1, beat_valid and done are 0, req_ready is 1 and reg_rdata reads 00h.
- R2: A write on the register port stores reg_wdata. Bits 7 and 2 always read back as 0.
- R3: For a read to an EDO bank (req_fpm=0), bits 6:5 set the clocks between consecutive beats: 00 gives 4, 01 gives 3, 10 gives 2 and 11 gives 4.
- R4: For a read to an FPM bank (req_fpm=1), bits 6:5 give a beat spacing of 4, 4, 3 and 4 clocks for 00, 01, 10 and 11.
- R5: For a write, bits 4:3 give a beat spacing of 4, 3, 2 and 4 clocks for 00, 01, 10 and 11, for either bank type.
- R6: A row miss is req_class 10, and code 11 is also treated as a row miss. The first beat_valid is high in clock period L after the accepting edge. For a read, L is 11, 10, 11 and 10 for leadoff bits 1:0 = 00, 01, 10 and 11. For a write, L is 7, 6, 7 and 6.
- R7: A page hit is req_class 00. Its first beat falls in period 7 for a read and period 4 for a write, whatever bits 1:0 hold. ras_n stays 0 throughout.
- R8: A page miss is req_class 01. ras_n is 1 for the precharge time: 3, 3, 4 and 4 clocks for bits 1:0 = 00, 01, 10 and 11. The row-miss leadoff then follows, so the first beat lands at precharge plus L. For the other classes ras_n is 0 during the burst.
- R9: Each burst has exactly four beat_valid pulses. Each pulse lasts one clock with cas_n at 0, and we_n is 0 on write beats and 1 on read beats. done pulses for one clock, in the period after the last beat.
- R10: req_ready is 1 only in IDLE. The register value sampled at the accepting edge sets the whole burst. A register write on that same edge, or during the burst, does not change it.
- R11: After a burst completes, the sequencer returns to idle with ras_n held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read data |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_class | input | 2 | 00 page hit, 01 page miss, 10/11 row miss |
| req_fpm | input | 1 | Target bank type: 1 = FPM, 0 = EDO |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| beat_valid | output | 1 | One-clock pulse per data beat |
| done | output | 1 | One-clock pulse after the last beat |

## Verification
A register write and the acceptance of a request can fall on the same clock edge. The bench provokes this by raising reg_we in the cycle where req_valid meets req_ready, with a rate field that differs from the stored one. The measured beat spacing must match the old register value, and a later readback must show the new value. A second test issues the same kind of write in the middle of a burst and checks that the spacing already under way does not change.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int TIM_W = 4;

    // configuration field positions (decoded by dram_seq_decode)
    localparam int RD_MSB   = 6;
    localparam int RD_LSB   = 5;
    localparam int WR_MSB   = 4;
    localparam int WR_LSB   = 3;
    localparam int LEAD_MSB = 1;
    localparam int LEAD_LSB = 0;
    localparam logic [7:0] RSVD_MASK = 8'h84;

    typedef enum logic [1:0] {
        ACC_HIT   = 2'b00,
        ACC_PMISS = 2'b01,
        ACC_RMISS = 2'b10,
        ACC_RALT  = 2'b11
    } acc_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [TIM_W-1:0] trp;
        logic [TIM_W-1:0] trcd;
        logic [TIM_W-1:0] col_wait;
        logic [TIM_W-1:0] hit_wait;
        logic [2:0]       spacing;
    } tim_t;

endpackage

// File: rtl/dram_seq_cfg.sv
module dram_seq_cfg
    import dram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= 8'h00;
        else if (we)
            cfg <= wdata & ~RSVD_MASK;
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg & RSVD_MASK) == 8'h00);

endmodule

// File: rtl/dram_seq_decode.sv
module dram_seq_decode
    import dram_seq_pkg::*;
#(
    parameter int RD_ROW_LEAD = 11,
    parameter int WR_ROW_LEAD = 7,
    parameter int RD_HIT_LEAD = 7,
    parameter int WR_HIT_LEAD = 4,
    parameter int TRCD_SLOW   = 4,
    parameter int TRP_SHORT   = 3
) (
    input  logic [1:0] rd_sel,
    input  logic [1:0] wr_sel,
    input  logic [1:0] lead_sel,
    input  logic       is_write,
    input  logic       is_fpm,
    output tim_t       tim
);

    logic [1:0] burst_sel;
    logic       fpm_read;
    int         row_lead;
    int         rcd;
    int         rp;
    int         hit_lead;

    always_comb begin
        burst_sel = is_write ? wr_sel : rd_sel;
        fpm_read  = !is_write && is_fpm;
        row_lead  = (is_write ? WR_ROW_LEAD : RD_ROW_LEAD) - int'(lead_sel[0]);
        rcd       = TRCD_SLOW - int'(lead_sel[0]);
        rp        = TRP_SHORT + int'(lead_sel[1]);
        hit_lead  = is_write ? WR_HIT_LEAD : RD_HIT_LEAD;

        unique case (burst_sel)
            2'b00:   tim.spacing = 3'd4;
            2'b01:   tim.spacing = fpm_read ? 3'd4 : 3'd3;
            2'b10:   tim.spacing = fpm_read ? 3'd3 : 3'd2;
            default: tim.spacing = 3'd4;
        endcase

        tim.trp      = TIM_W'(rp);
        tim.trcd     = TIM_W'(rcd);
        tim.col_wait = TIM_W'(row_lead - 1 - rcd);
        tim.hit_wait = TIM_W'(hit_lead - 1);
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_class,
    input  tim_t       tim,
    output logic       req_ready,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       beat_valid,
    output logic       done
);

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    seq_state_e        state_q, state_d;
    logic [TIM_W-1:0]  cnt_q, cnt_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    tim_t              tim_q, tim_d;
    logic              wr_q, wr_d;
    logic              open_q, open_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        beat_d  = beat_q;
        tim_d   = tim_q;
        wr_d    = wr_q;
        open_d  = open_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                tim_d = tim;
                wr_d  = req_write;
                case (acc_class_e'(req_class))
                    ACC_HIT: begin
                        state_d = ST_COL;
                        cnt_d   = tim.hit_wait - TIM_W'(1);
                    end
                    ACC_PMISS: begin
                        state_d = ST_PRECH;
                        cnt_d   = tim.trp - TIM_W'(1);
                    end
                    default: begin
                        state_d = ST_ROW;
                        cnt_d   = tim.trcd - TIM_W'(1);
                    end
                endcase
            end
            ST_PRECH: if (cnt_q == '0) begin
                state_d = ST_ROW;
                cnt_d   = tim_q.trcd - TIM_W'(1);
            end else begin
                cnt_d = cnt_q - TIM_W'(1);
            end
            ST_ROW: if (cnt_q == '0) begin
                state_d = ST_COL;
                cnt_d   = tim_q.col_wait - TIM_W'(1);
            end else begin
                cnt_d = cnt_q - TIM_W'(1);
            end
            ST_COL: if (cnt_q == '0) begin
                state_d = ST_CAS;
            end else begin
                cnt_d = cnt_q - TIM_W'(1);
            end
            ST_CAS: if (beat_q == BEAT_W'(BEATS - 1)) begin
                state_d = ST_DONE;
                beat_d  = '0;
            end else begin
                state_d = ST_GAP;
                beat_d  = beat_q + BEAT_W'(1);
                cnt_d   = TIM_W'(tim_q.spacing) - TIM_W'(2);
            end
            ST_GAP: if (cnt_q == '0) begin
                state_d = ST_CAS;
            end else begin
                cnt_d = cnt_q - TIM_W'(1);
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                open_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            tim_q   <= '0;
            wr_q    <= 1'b0;
            open_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            beat_q  <= beat_d;
            tim_q   <= tim_d;
            wr_q    <= wr_d;
            open_q  <= open_d;
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        ras_n      = (state_q == ST_PRECH) || ((state_q == ST_IDLE) && !open_q);
        cas_n      = (state_q != ST_CAS);
        beat_valid = (state_q == ST_CAS);
        done       = (state_q == ST_DONE);
        we_n       = !(wr_q && ((state_q == ST_COL) || (state_q == ST_CAS) ||
                                (state_q == ST_GAP)));
    end

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(tim_q));

    // R9
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_valid));

    // R9
    beat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> !beat_valid);

    // R8
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dram_seq_pkg::*;
#(
    parameter int BEATS       = 4,
    parameter int RD_ROW_LEAD = 11,
    parameter int WR_ROW_LEAD = 7,
    parameter int RD_HIT_LEAD = 7,
    parameter int WR_HIT_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  logic [1:0] req_class,
    input  logic       req_fpm,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       beat_valid,
    output logic       done
);

    logic [7:0] cfg;
    tim_t       tim;

    dram_seq_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    assign reg_rdata = cfg;

    dram_seq_decode #(
        .RD_ROW_LEAD (RD_ROW_LEAD),
        .WR_ROW_LEAD (WR_ROW_LEAD),
        .RD_HIT_LEAD (RD_HIT_LEAD),
        .WR_HIT_LEAD (WR_HIT_LEAD)
    ) u_dec (
        .rd_sel   (cfg[RD_MSB:RD_LSB]),
        .wr_sel   (cfg[WR_MSB:WR_LSB]),
        .lead_sel (cfg[LEAD_MSB:LEAD_LSB]),
        .is_write (req_write),
        .is_fpm   (req_fpm),
        .tim      (tim)
    );

    dram_seq_fsm #(
        .BEATS (BEATS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_class  (req_class),
        .tim        (tim),
        .req_ready  (req_ready),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .beat_valid (beat_valid),
        .done       (done)
    );

endmodule

// File: tb/dram_burst_seq_tb.sv
`timescale 1ns/1ps
module dram_burst_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [1:0] req_class = 2'b00;
    logic       req_fpm = 1'b0;
    logic       ras_n, cas_n, we_n, beat_valid, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int m_first, m_last, m_beats, m_done, m_prech;
    bit m_strobe_bad, m_busy_bad;

    always #2 clk = ~clk;

    dram_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_class(req_class), .req_fpm(req_fpm),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .beat_valid(beat_valid),
        .done(done)
    );

    // {cfg, write, fpm, class, first beat period, spacing, precharge clocks}
    localparam logic [22:0] VEC [16] = '{
        {8'h00, 1'b0, 1'b0, 2'b10, 5'd11, 3'd4, 3'd0},
        {8'h01, 1'b0, 1'b0, 2'b10, 5'd10, 3'd4, 3'd0},
        {8'h20, 1'b0, 1'b0, 2'b00, 5'd7,  3'd3, 3'd0},
        {8'h40, 1'b0, 1'b0, 2'b00, 5'd7,  3'd2, 3'd0},
        {8'h40, 1'b0, 1'b1, 2'b00, 5'd7,  3'd3, 3'd0},
        {8'h20, 1'b0, 1'b1, 2'b10, 5'd11, 3'd4, 3'd0},
        {8'hE4, 1'b0, 1'b0, 2'b00, 5'd7,  3'd4, 3'd0},
        {8'h10, 1'b1, 1'b0, 2'b10, 5'd7,  3'd2, 3'd0},
        {8'h0B, 1'b1, 1'b0, 2'b01, 5'd10, 3'd3, 3'd4},
        {8'h02, 1'b0, 1'b0, 2'b01, 5'd15, 3'd4, 3'd4},
        {8'h01, 1'b0, 1'b1, 2'b01, 5'd13, 3'd4, 3'd3},
        {8'h00, 1'b1, 1'b0, 2'b00, 5'd4,  3'd4, 3'd0},
        {8'h03, 1'b1, 1'b1, 2'b00, 5'd4,  3'd4, 3'd0},
        {8'h18, 1'b1, 1'b1, 2'b00, 5'd4,  3'd4, 3'd0},
        {8'h43, 1'b0, 1'b0, 2'b11, 5'd10, 3'd2, 3'd0},
        {8'h08, 1'b1, 1'b1, 2'b01, 5'd10, 3'd3, 3'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        // R2: reserved bits 7 and 2 read as zero
        chk(reg_rdata == (v & 8'h7B), "R2", int'(reg_rdata), int'(v & 8'h7B));
    endtask

    // wcyc: -1 none, 0 same edge as acceptance, n>0 during period n
    task automatic burst(input logic wr, input logic fpm, input logic [1:0] cls,
                         input int wcyc, input logic [7:0] wval);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_fpm   = fpm;
        req_class = cls;
        if (wcyc == 0) begin
            reg_we = 1'b1;
            reg_wdata = wval;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b0;
        m_first = 0; m_last = 0; m_beats = 0; m_done = 0; m_prech = 0;
        m_strobe_bad = 1'b0; m_busy_bad = 1'b0;
        for (int c = 1; c < 80 && m_done == 0; c++) begin
            if (c == wcyc) begin
                reg_we = 1'b1;
                reg_wdata = wval;
            end else begin
                reg_we = 1'b0;
            end
            if (beat_valid) begin
                if (m_beats == 0) m_first = c;
                m_last = c;
                m_beats++;
                if (cas_n !== 1'b0 || we_n !== !wr) m_strobe_bad = 1'b1;
            end
            if (ras_n) m_prech++;
            if (done) m_done = c;
            if (req_ready) m_busy_bad = 1'b1;
            if (m_done == 0) @(negedge clk);
        end
        reg_we = 1'b0;
    endtask

    logic [22:0] vv;
    logic [7:0]  v_cfg;
    logic        v_wr, v_fpm;
    logic [1:0]  v_cls;
    int          v_l, v_s, v_p;
    string       lead_tag, rate_tag;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ras_n === 1'b1, "R1", int'(ras_n), 1);
        chk(cas_n === 1'b1 && we_n === 1'b1, "R1", int'({cas_n, we_n}), 3);
        chk(beat_valid === 1'b0 && done === 1'b0, "R1", int'({beat_valid, done}), 0);
        chk(req_ready === 1'b1, "R1", int'(req_ready), 1);
        chk(reg_rdata === 8'h00, "R1", int'(reg_rdata), 0);

        for (int i = 0; i < 16; i++) begin
            vv = VEC[i];
            {v_cfg, v_wr, v_fpm, v_cls} = vv[22:11];
            v_l = int'(vv[10:6]);
            v_s = int'(vv[5:3]);
            v_p = int'(vv[2:0]);
            lead_tag = (v_cls == 2'b00) ? "R7" : (v_cls == 2'b01) ? "R8" : "R6";
            rate_tag = v_wr ? "R5" : (v_fpm ? "R4" : "R3");
            write_cfg(v_cfg);
            burst(v_wr, v_fpm, v_cls, -1, 8'h00);
            chk(m_first == v_l, lead_tag, m_first, v_l);
            chk(m_last - m_first == 3 * v_s, rate_tag, m_last - m_first, 3 * v_s);
            chk(m_prech == v_p, "R8", m_prech, v_p);
            chk(m_beats == 4 && m_done == m_last + 1, "R9", m_done, m_last + 1);
            chk(!m_strobe_bad, "R9", int'(m_strobe_bad), 0);
            chk(!m_busy_bad, "R10", int'(m_busy_bad), 0);
            @(negedge clk);
            // R11 idle with page held open
            chk(ras_n === 1'b0 && req_ready === 1'b1, "R11", int'({ras_n, req_ready}), 1);
        end

        // R10: register write during a burst does not alter it
        write_cfg(8'h00);
        burst(1'b0, 1'b0, 2'b00, 3, 8'h40);
        chk(m_first == 7, "R10", m_first, 7);
        chk(m_last == 19, "R10", m_last, 19);
        chk(reg_rdata == 8'h40, "R10", int'(reg_rdata), 8'h40);

        // R10: register write on the accepting edge, old value governs
        burst(1'b0, 1'b0, 2'b00, 0, 8'h00);
        chk(m_last - m_first == 6, "R10", m_last - m_first, 6);
        chk(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
        burst(1'b0, 1'b0, 2'b00, -1, 8'h00);
        chk(m_last - m_first == 12, "R3", m_last - m_first, 12);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule